// File: doc/BRIEF.md
# Word-Loaded Shift Register with Serial Scalar Tap

This block is a wide holding register placed between a 32-bit host port and two wide cryptographic datapaths, one symmetric and one elliptic-curve. It has no wide load path. It is filled one 32-bit word at a time: each load moves the current contents up by one word width and places the new word in the low bits. The whole register is always visible on a parallel output, so the downstream datapaths can read it in full.

A second control moves the register up by one bit and fills the vacated low bit with zero. The bit that leaves the top is captured on a registered serial output. A point-multiplication ladder loads its scalar into this register and then steps once per iteration. It reads the scalar from the most significant bit downwards, so the scalar needs no register of its own. A synchronous clear empties the register, and it takes priority over loads and shifts.

Top module: `shared_iface_reg`

## Requirements
- R1: While the synchronous reset `rst` is high, and after the first clock edge that sees it, `par_out` and `ser_out` are all zero.
- R2: A load (`load_en`=1, `clr`=0) makes `par_out` equal to the previous value's low REG_W-WORD_W bits followed by `word_in` in bits [WORD_W-1:0]. This takes effect one clock later.
- R3: A shift (`shift_en`=1, `load_en`=0, `clr`=0) makes `par_out` equal to the previous value moved up one bit with a zero in bit 0. `ser_out` takes the previous bit REG_W-1.
- R4: `ser_out` changes only on a shift or a clear. On idle cycles and on loads it keeps its value.
- R5: When `load_en` and `shift_en` are both high, the load happens and the shift does not, and `ser_out` is unchanged.
- R6: `clr`=1 zeroes `par_out` and `ser_out` on the next edge, whatever `load_en` and `shift_en` are.
- R7: With REG_W=163 and WORD_W=32, six loads w0..w5 leave w5 in bits [31:0] and w1 in bits [159:128]. Only w0[2:0] remains, in bits [162:160].
- R8: With no control asserted, `par_out` holds its value.
- R9: After a scalar is loaded, REG_W successive shifts present its bits on `ser_out` in order from bit REG_W-1 down to bit 0, one per shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear; highest priority |
| load_en | input | 1 | Word load with shift up by WORD_W |
| shift_en | input | 1 | One-bit shift up with top bit to ser_out |
| word_in | input | WORD_W | Word inserted in the low bits on load |
| ser_out | output | 1 | Last bit shifted out of the top |
| par_out | output | REG_W | Full register contents |

## Verification
The bench builds the block with its defaults, REG_W=163 and WORD_W=32. Because 163 is not a multiple of 32, a run of six loads pushes the first word partly out of the top. This exposes the truncation boundary at bits [162:160]. The same width allows a complete scan of 163 shifts, which checks each scalar bit in order, the zeros that fill from below, and the register ending empty.

// File: rtl/slr_pkg.sv
package slr_pkg;
  // Per-cycle action on the register, listed from lowest to highest priority.
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_SHIFT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } slr_op_e;
endpackage

// File: rtl/slr_ctrl.sv
module slr_ctrl
  import slr_pkg::*;
(
  input  logic    clr,
  input  logic    load_en,
  input  logic    shift_en,
  output slr_op_e op
);
  // Priority: clear, then load, then shift.
  always_comb begin
    if (clr)           op = OP_CLEAR;
    else if (load_en)  op = OP_LOAD;
    else if (shift_en) op = OP_SHIFT;
    else               op = OP_HOLD;
  end
endmodule

// File: rtl/slr_store.sv
module slr_store
  import slr_pkg::*;
#(
  parameter int REG_W  = 163,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  slr_op_e           op,
  input  logic [WORD_W-1:0] word_in,
  output logic [REG_W-1:0]  q
);
  logic [REG_W-1:0] load_val;
  logic [REG_W-1:0] shift_val;

  // Word insertion: the register either keeps older words above the new one,
  // or, if it is no wider than a word, takes the low bits of the word.
  generate
    if (REG_W > WORD_W) begin : g_wide
      localparam int KEEP_W = REG_W - WORD_W;
      assign load_val = {q[KEEP_W-1:0], word_in};
    end else begin : g_narrow
      assign load_val = word_in[REG_W-1:0];
    end
  endgenerate

  assign shift_val = {q[REG_W-2:0], 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      unique case (op)
        OP_CLEAR: q <= '0;
        OP_LOAD:  q <= load_val;
        OP_SHIFT: q <= shift_val;
        default:  q <= q;
      endcase
    end
  end
endmodule

// File: rtl/slr_tap.sv
module slr_tap
  import slr_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  slr_op_e op,
  input  logic    top_bit,
  output logic    ser
);
  // Registered copy of the bit leaving the top of the register.
  always_ff @(posedge clk) begin
    if (rst)                 ser <= 1'b0;
    else if (op == OP_CLEAR) ser <= 1'b0;
    else if (op == OP_SHIFT) ser <= top_bit;
  end
endmodule

// File: rtl/shared_iface_reg.sv
module shared_iface_reg
  import slr_pkg::*;
#(
  parameter int REG_W  = 163,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              load_en,
  input  logic              shift_en,
  input  logic [WORD_W-1:0] word_in,
  output logic              ser_out,
  output logic [REG_W-1:0]  par_out
);
  localparam int TOP = REG_W - 1;

  slr_op_e op;

  slr_ctrl u_ctrl (
    .clr      (clr),
    .load_en  (load_en),
    .shift_en (shift_en),
    .op       (op)
  );

  slr_store #(.REG_W(REG_W), .WORD_W(WORD_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .op      (op),
    .word_in (word_in),
    .q       (par_out)
  );

  slr_tap u_tap (
    .clk     (clk),
    .rst     (rst),
    .op      (op),
    .top_bit (par_out[TOP]),
    .ser     (ser_out)
  );
endmodule

// File: rtl/shared_iface_reg_chk.sv
module shared_iface_reg_chk #(
  parameter int REG_W  = 163,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              clr,
  input logic              load_en,
  input logic              shift_en,
  input logic [WORD_W-1:0] word_in,
  input logic              ser_out,
  input logic [REG_W-1:0]  par_out
);
  localparam int KEEP_W = REG_W - WORD_W;

  // R2 word load shifts up by a word
  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    (load_en && !clr) |=>
      par_out == {$past(par_out[KEEP_W-1:0]), $past(word_in)});

  // R3 one-bit shift and serial capture
  p_shift_r3: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !load_en && !clr) |=>
      (par_out == {$past(par_out[REG_W-2:0]), 1'b0}) &&
      (ser_out == $past(par_out[REG_W-1])));

  // R4 and R5: serial output steady without a shift
  p_ser_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!clr && (load_en || !shift_en)) |=> $stable(ser_out));

  // R6 clear wins
  p_clear_r6: assert property (@(posedge clk) disable iff (rst)
    clr |=> (par_out == '0) && !ser_out);

  // R8 idle hold
  p_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (!clr && !load_en && !shift_en) |=> $stable(par_out));
endmodule

bind shared_iface_reg shared_iface_reg_chk #(.REG_W(REG_W), .WORD_W(WORD_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .clr      (clr),
  .load_en  (load_en),
  .shift_en (shift_en),
  .word_in  (word_in),
  .ser_out  (ser_out),
  .par_out  (par_out)
);

// File: tb/shared_iface_reg_tb_top.sv
`timescale 1ns/1ps
module shared_iface_reg_tb_top;
  localparam int REG_W  = 163;
  localparam int WORD_W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              clr = 1'b0;
  logic              load_en = 1'b0;
  logic              shift_en = 1'b0;
  logic [WORD_W-1:0] word_in = '0;
  logic              ser_out;
  logic [REG_W-1:0]  par_out;

  logic [REG_W-1:0]  exp_par;
  logic              exp_ser;
  int                n_chk = 0;
  int                n_bad = 0;

  always #10 clk = ~clk;

  shared_iface_reg #(.REG_W(REG_W), .WORD_W(WORD_W)) dut_i (
    .clk(clk), .rst(rst), .clr(clr), .load_en(load_en), .shift_en(shift_en),
    .word_in(word_in), .ser_out(ser_out), .par_out(par_out)
  );

  task automatic check(input string req);
    n_chk++;
    if (par_out !== exp_par || ser_out !== exp_ser) begin
      n_bad++;
      $display("FAIL %s par=%h ser=%b expected par=%h ser=%b",
               req, par_out, ser_out, exp_par, exp_ser);
    end
  endtask

  // Drive one cycle on the falling edge, update the model, sample at next falling edge.
  task automatic step(input logic c, input logic l, input logic s,
                      input logic [WORD_W-1:0] w, input string req);
    clr = c; load_en = l; shift_en = s; word_in = w;
    if (c) begin
      exp_par = '0; exp_ser = 1'b0;
    end else if (l) begin
      exp_par = {exp_par[REG_W-WORD_W-1:0], w};
    end else if (s) begin
      exp_ser = exp_par[REG_W-1];
      exp_par = exp_par << 1;
    end
    @(negedge clk);
    clr = 1'b0; load_en = 1'b0; shift_en = 1'b0;
    check(req);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    exp_par = '0; exp_ser = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R1");
    rst = 1'b0;
  endtask

  task automatic t_six_loads;
    logic [WORD_W-1:0] w [6];
    w[0] = 32'hDEAD_BEEF; w[1] = 32'h1234_5678; w[2] = 32'h0F0F_0F0F;
    w[3] = 32'hA5A5_5A5A; w[4] = 32'h8000_0001; w[5] = 32'hCAFE_F00D;
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 1'b0, w[i], "R2");
    n_chk++;
    if (par_out[162:160] !== w[0][2:0] || par_out[159:128] !== w[1] ||
        par_out[31:0] !== w[5]) begin
      n_bad++;
      $display("FAIL R7 top=%h mid=%h low=%h expected %h %h %h",
               par_out[162:160], par_out[159:128], par_out[31:0],
               w[0][2:0], w[1], w[5]);
    end
  endtask

  task automatic t_shift_hold;
    step(1'b0, 1'b0, 1'b1, '0, "R3");    // top bit 1 (0xF bits)
    step(1'b0, 1'b0, 1'b1, '0, "R3");
    step(1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF, "R8");
    step(1'b0, 1'b1, 1'b0, 32'h0000_0077, "R4");
    step(1'b0, 1'b1, 1'b1, 32'h1357_9BDF, "R5");
    step(1'b0, 1'b0, 1'b0, '0, "R8");
  endtask

  task automatic t_clear;
    step(1'b1, 1'b1, 1'b1, 32'hFFFF_FFFF, "R6");
    n_chk++;
    if (par_out !== '0 || ser_out !== 1'b0) begin
      n_bad++;
      $display("FAIL R6 par=%h ser=%b expected par=0 ser=0", par_out, ser_out);
    end
  endtask

  task automatic t_scan;
    logic [REG_W-1:0] k;
    k = '0;
    for (int i = 0; i < 6; i++) begin
      logic [WORD_W-1:0] w;
      w = 32'h9E37_79B9 ^ (32'h0101_0101 * (i + 1));
      k = {k[REG_W-WORD_W-1:0], w};
      step(1'b0, 1'b1, 1'b0, w, "R2");
    end
    for (int b = REG_W - 1; b >= 0; b--) begin
      step(1'b0, 1'b0, 1'b1, '0, "R3");
      n_chk++;
      if (ser_out !== k[b]) begin
        n_bad++;
        $display("FAIL R9 bit %0d ser=%b expected %b", b, ser_out, k[b]);
      end
    end
    n_chk++;
    if (par_out !== '0) begin
      n_bad++;
      $display("FAIL R9 par=%h expected 0 after full scan", par_out);
    end
  endtask

  initial begin
    #(20 * 5000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_six_loads();
    t_shift_hold();
    t_clear();
    t_scan();
    t_clear();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule